// File: doc/BRIEF.md
# Pad Configuration Register Bank with Commit Guard

This block keeps the per-pin pad settings of one general-purpose I/O port: output direction, hand-over to a peripheral function, open-drain mode, pull-up, pull-down, drive strength and slew control, and whether the digital input path is enabled. Software reaches the settings over a simple word-addressed register bus. Every setting leaves the block as a registered per-pin vector that the pad ring uses directly.

Some pins may be set aside for the debug port. These pins come out of reset already handed to their peripheral, with pull-up and digital path enabled. A two-stage guard protects them from accidental reprogramming. First, a key word written to the lock register opens the port. Only while the port is open can software set the pin's bit in the commit mask. Only pins whose commit bit is set accept writes to their peripheral-select, pull-up, pull-down and digital-enable bits. The reserved pins, the pins that have a pad, and the key are all instance parameters.

Top module: `gpio_padcfg`

## Requirements
- R1: In reset, every non-reserved pin has peripheral-select, pull-up, pull-down and digital-enable at 0. Reserved pins (`RSV_MASK`) have peripheral-select, pull-up and digital-enable at 1. Direction, open-drain and slew are 0. The 2 mA select is all ones and the 4 mA and 8 mA selects are 0.
- R2: In reset, the port is locked: a read of the lock register at 0x520 returns 1. The commit mask at 0x524 resets to the inverse of `RSV_MASK`.
- R3: Direction (0x400), open-drain (0x50C) and slew (0x518) take every written bit of a connected pin. A read request presents its data on `bus_rdata` in the next cycle, with bits above the pin count at 0. An address that maps to no register reads 0, and a write to it changes no output.
- R4: Writing the key `LOCK_KEY` to 0x520 unlocks the port, and the register then reads 0. Writing any other value locks the port, and the register reads 1.
- R5: A write to the commit mask takes effect only while the port is unlocked. Even then, only bits of reserved connected pins change. Bits of other pins keep their reset value.
- R6: Peripheral-select (0x420), pull-up (0x510), pull-down (0x514) and digital-enable (0x51C) accept a written bit only for a connected pin whose commit bit is 1. Bits of other pins keep their value.
- R7: The drive selects are 2 mA (0x500), 4 mA (0x504) and 8 mA (0x508). Writing a 1 to a pin's bit in one of them selects that strength and clears the pin's bit in the other two. Writing a 0 has no effect. Each pin always has exactly one strength selected.
- R8: For pins outside `CONN_MASK`, writes change no register or pad output, and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pad_dir | output | PINS | 1 = pin drives out |
| pad_alt | output | PINS | 1 = pin handed to a peripheral |
| pad_od | output | PINS | Open-drain enable |
| pad_pu | output | PINS | Pull-up enable |
| pad_pd | output | PINS | Pull-down enable |
| pad_drv2 | output | PINS | 2 mA strength selected |
| pad_drv4 | output | PINS | 4 mA strength selected |
| pad_drv8 | output | PINS | 8 mA strength selected |
| pad_slew | output | PINS | Slew-rate control enable |
| pad_den | output | PINS | Digital path enable |

## Verification
The bench uses a port with four reserved pins and one pin without a pad. It sweeps bit patterns over every register while the port is locked, then after unlocking and committing, then after relocking.

A design that guarded the wrong registers would let a reserved pin lose its peripheral while the port is still locked. A design that checked the lock too weakly would accept commit-mask writes without the key, or after a non-key write has relocked the port. A design that let zero writes clear a drive bit would leave a pin with no strength selected. The bench also looks for a disconnected pin whose bits move or read back non-zero.

// File: rtl/gpio_padcfg_pkg.sv
package gpio_padcfg_pkg;
  localparam int ADDR_W = 12;
  localparam int NCFG   = 7;
  localparam int CF_DIR = 0, CF_ALT = 1, CF_OD = 2, CF_PU = 3,
                 CF_PD  = 4, CF_SLEW = 5, CF_DEN = 6;

  localparam logic [ADDR_W-1:0] OFS_DRV2   = 12'h500;
  localparam logic [ADDR_W-1:0] OFS_DRV4   = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_DRV8   = 12'h508;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;

  function automatic logic [ADDR_W-1:0] cfg_offset(input int idx);
    case (idx)
      CF_DIR:  return 12'h400;
      CF_ALT:  return 12'h420;
      CF_OD:   return 12'h50C;
      CF_PU:   return 12'h510;
      CF_PD:   return 12'h514;
      CF_SLEW: return 12'h518;
      default: return 12'h51C;
    endcase
  endfunction

  // settings that only committed pins may change
  function automatic logic cfg_guarded(input int idx);
    return (idx == CF_ALT) || (idx == CF_PU) || (idx == CF_PD) || (idx == CF_DEN);
  endfunction

  // settings that reserved pins leave reset with set
  function automatic logic cfg_rsv_set(input int idx);
    return (idx == CF_ALT) || (idx == CF_PU) || (idx == CF_DEN);
  endfunction
endpackage

// File: rtl/gpio_padcfg_cfgreg.sv
module gpio_padcfg_cfgreg #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (wr_en) q <= (q & ~wr_mask) | (wr_data & wr_mask);
  end
endmodule

// File: rtl/gpio_padcfg_drive.sv
module gpio_padcfg_drive #(
  parameter int              PINS      = 8,
  parameter logic [PINS-1:0] CONN_MASK = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      sel_we,   // bit0 2 mA, bit1 4 mA, bit2 8 mA
  input  logic [PINS-1:0] wr_data,
  output logic [PINS-1:0] drv2,
  output logic [PINS-1:0] drv4,
  output logic [PINS-1:0] drv8
);
  logic [PINS-1:0] take;
  assign take = wr_data & CONN_MASK & {PINS{|sel_we}};

  always_ff @(posedge clk) begin
    if (rst) begin
      drv2 <= '1;
      drv4 <= '0;
      drv8 <= '0;
    end else begin
      drv2 <= (drv2 & ~take) | (take & {PINS{sel_we[0]}});
      drv4 <= (drv4 & ~take) | (take & {PINS{sel_we[1]}});
      drv8 <= (drv8 & ~take) | (take & {PINS{sel_we[2]}});
    end
  end
endmodule

// File: rtl/gpio_padcfg_lock.sv
module gpio_padcfg_lock #(
  parameter int              PINS      = 8,
  parameter logic [PINS-1:0] RSV_MASK  = '0,
  parameter logic [PINS-1:0] CONN_MASK = '1,
  parameter logic [31:0]     LOCK_KEY  = 32'hC0DE_600D
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lock_we,
  input  logic            commit_we,
  input  logic [31:0]     wr_data,
  output logic            locked,
  output logic [PINS-1:0] commit
);
  localparam logic [PINS-1:0] CWM = RSV_MASK & CONN_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b1;
      commit <= ~RSV_MASK;
    end else begin
      if (lock_we) locked <= (wr_data != LOCK_KEY);
      if (commit_we && !locked)
        commit <= (commit & ~CWM) | (wr_data[PINS-1:0] & CWM);
    end
  end
endmodule

// File: rtl/gpio_padcfg.sv
module gpio_padcfg
  import gpio_padcfg_pkg::*;
#(
  parameter int              PINS      = 8,
  parameter logic [PINS-1:0] RSV_MASK  = 8'h80,
  parameter logic [PINS-1:0] CONN_MASK = 8'hFF,
  parameter logic [31:0]     LOCK_KEY  = 32'hC0DE_600D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [PINS-1:0]   pad_dir,
  output logic [PINS-1:0]   pad_alt,
  output logic [PINS-1:0]   pad_od,
  output logic [PINS-1:0]   pad_pu,
  output logic [PINS-1:0]   pad_pd,
  output logic [PINS-1:0]   pad_drv2,
  output logic [PINS-1:0]   pad_drv4,
  output logic [PINS-1:0]   pad_drv8,
  output logic [PINS-1:0]   pad_slew,
  output logic [PINS-1:0]   pad_den
);
  localparam int WA = ADDR_W - 2;

  logic              wr_go, rd_go;
  logic [WA-1:0]     word_addr;
  logic [PINS-1:0]   cfg_q [NCFG];
  logic [PINS-1:0]   commit_q;
  logic              locked_q;
  logic [31:0]       rd_next;

  assign wr_go     = bus_sel & bus_we;
  assign rd_go     = bus_sel & ~bus_we;
  assign word_addr = bus_addr[ADDR_W-1:2];

  generate
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      localparam logic [ADDR_W-1:0] OFS = cfg_offset(g);
      localparam logic [PINS-1:0]   RV  = cfg_rsv_set(g) ? RSV_MASK : '0;
      logic [PINS-1:0] wm;
      assign wm = cfg_guarded(g) ? (CONN_MASK & commit_q) : CONN_MASK;
      gpio_padcfg_cfgreg #(.W(PINS), .RST_VAL(RV)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_go && (word_addr == OFS[ADDR_W-1:2])),
        .wr_mask (wm),
        .wr_data (bus_wdata[PINS-1:0]),
        .q       (cfg_q[g])
      );
    end
  endgenerate

  gpio_padcfg_drive #(.PINS(PINS), .CONN_MASK(CONN_MASK)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .sel_we  ({wr_go && (word_addr == OFS_DRV8[ADDR_W-1:2]),
               wr_go && (word_addr == OFS_DRV4[ADDR_W-1:2]),
               wr_go && (word_addr == OFS_DRV2[ADDR_W-1:2])}),
    .wr_data (bus_wdata[PINS-1:0]),
    .drv2    (pad_drv2),
    .drv4    (pad_drv4),
    .drv8    (pad_drv8)
  );

  gpio_padcfg_lock #(.PINS(PINS), .RSV_MASK(RSV_MASK), .CONN_MASK(CONN_MASK),
                     .LOCK_KEY(LOCK_KEY)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .lock_we   (wr_go && (word_addr == OFS_LOCK[ADDR_W-1:2])),
    .commit_we (wr_go && (word_addr == OFS_COMMIT[ADDR_W-1:2])),
    .wr_data   (bus_wdata),
    .locked    (locked_q),
    .commit    (commit_q)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCFG; i++)
      if (word_addr == cfg_offset(i)[ADDR_W-1:2]) rd_next = 32'(cfg_q[i] & CONN_MASK);
    if (word_addr == OFS_DRV2[ADDR_W-1:2])   rd_next = 32'(pad_drv2 & CONN_MASK);
    if (word_addr == OFS_DRV4[ADDR_W-1:2])   rd_next = 32'(pad_drv4 & CONN_MASK);
    if (word_addr == OFS_DRV8[ADDR_W-1:2])   rd_next = 32'(pad_drv8 & CONN_MASK);
    if (word_addr == OFS_LOCK[ADDR_W-1:2])   rd_next = {31'b0, locked_q};
    if (word_addr == OFS_COMMIT[ADDR_W-1:2]) rd_next = 32'(commit_q & CONN_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_next;
    else            bus_rdata <= '0;
  end

  assign pad_dir  = cfg_q[CF_DIR];
  assign pad_alt  = cfg_q[CF_ALT];
  assign pad_od   = cfg_q[CF_OD];
  assign pad_pu   = cfg_q[CF_PU];
  assign pad_pd   = cfg_q[CF_PD];
  assign pad_slew = cfg_q[CF_SLEW];
  assign pad_den  = cfg_q[CF_DEN];
endmodule

// File: rtl/gpio_padcfg_chk.sv
module gpio_padcfg_chk #(
  parameter int              PINS      = 8,
  parameter logic [PINS-1:0] CONN_MASK = '1
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [11:0]     bus_addr,
  input logic [31:0]     bus_rdata,
  input logic [PINS-1:0] pad_dir,
  input logic [PINS-1:0] pad_alt,
  input logic [PINS-1:0] pad_od,
  input logic [PINS-1:0] pad_pu,
  input logic [PINS-1:0] pad_pd,
  input logic [PINS-1:0] pad_drv2,
  input logic [PINS-1:0] pad_drv4,
  input logic [PINS-1:0] pad_drv8,
  input logic [PINS-1:0] pad_slew,
  input logic [PINS-1:0] pad_den,
  input logic [PINS-1:0] commit_q,
  input logic            locked_q
);
  generate
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      assert_drive_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot({pad_drv2[p], pad_drv4[p], pad_drv8[p]}));
    end
  endgenerate

  assert_guard_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((~$past(commit_q)) & (($past(pad_alt) ^ pad_alt) | ($past(pad_pu) ^ pad_pu) |
                           ($past(pad_pd) ^ pad_pd) | ($past(pad_den) ^ pad_den))) == '0);

  assert_commit_unlocked_R5: assert property (@(posedge clk) disable iff (rst)
    (commit_q != $past(commit_q)) |-> !$past(locked_q));

  assert_unconn_still_R8: assert property (@(posedge clk) disable iff (rst)
    (~CONN_MASK & (($past(pad_dir) ^ pad_dir) | ($past(pad_od) ^ pad_od) |
                   ($past(pad_slew) ^ pad_slew) | ($past(pad_alt) ^ pad_alt) |
                   ($past(pad_drv2) ^ pad_drv2) | ($past(pad_den) ^ pad_den))) == '0);

  assert_lock_read_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == 12'h520) |=> (bus_rdata == {31'b0, $past(locked_q)}));
endmodule

bind gpio_padcfg gpio_padcfg_chk #(.PINS(PINS), .CONN_MASK(CONN_MASK)) u_chk (.*);

// File: tb/gpio_padcfg_bench.sv
module gpio_padcfg_bench;
  localparam logic [7:0]  RSV  = 8'h0F;
  localparam logic [7:0]  CONN = 8'h7F;
  localparam logic [31:0] KEY  = 32'h5EC0_7A11;
  localparam logic [11:0] A_LIST [12] = '{12'h400, 12'h420, 12'h50C, 12'h510, 12'h514,
                                          12'h518, 12'h51C, 12'h500, 12'h504, 12'h508,
                                          12'h520, 12'h524};

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pad_dir, pad_alt, pad_od, pad_pu, pad_pd, pad_drv2, pad_drv4, pad_drv8,
              pad_slew, pad_den;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // expected state, indexed as A_LIST entries 0..9, plus lock and commit
  logic [7:0] e [10];
  logic [7:0] e_commit;
  bit         e_locked;

  always #5 clk = ~clk;

  gpio_padcfg #(.PINS(8), .RSV_MASK(RSV), .CONN_MASK(CONN), .LOCK_KEY(KEY)) u_gpio_padcfg (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_dir(pad_dir), .pad_alt(pad_alt),
    .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_drv2(pad_drv2),
    .pad_drv4(pad_drv4), .pad_drv8(pad_drv8), .pad_slew(pad_slew), .pad_den(pad_den));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      1, 3, 4, 6: return "R6";
      7, 8, 9:    return "R7";
      10:         return "R4";
      11:         return "R5";
      default:    return "R3";
    endcase
  endfunction

  task automatic model_reset();
    e[0] = 0; e[2] = 0; e[5] = 0; e[4] = 0;
    e[1] = RSV; e[3] = RSV; e[6] = RSV;
    e[7] = 8'hFF; e[8] = 0; e[9] = 0;
    e_commit = ~RSV; e_locked = 1;
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    logic [7:0] m;
    for (int i = 0; i < 12; i++) begin
      if (a != A_LIST[i]) continue;
      if (i <= 6) begin
        m = (i == 1 || i == 3 || i == 4 || i == 6) ? (CONN & e_commit) : CONN;
        e[i] = (e[i] & ~m) | (d[7:0] & m);
      end else if (i <= 9) begin
        m = d[7:0] & CONN;
        for (int k = 7; k <= 9; k++) e[k] = (k == i) ? (e[k] | m) : (e[k] & ~m);
      end else if (i == 10) begin
        e_locked = (d != KEY);
      end else if (!e_locked) begin
        m = RSV & CONN;
        e_commit = (e_commit & ~m) | (d[7:0] & m);
      end
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic check_all(input string phase);
    logic [31:0] v;
    for (int i = 0; i < 12; i++) begin
      rd(A_LIST[i], v);
      if (i < 10)       chk({phase, " ", tag_of(i), " read"}, v, {24'b0, e[i] & CONN});
      else if (i == 10) chk({phase, " R4 lock read"}, v, {31'b0, e_locked});
      else              chk({phase, " R5 commit read"}, v, {24'b0, e_commit & CONN});
    end
    chk({phase, " R3 pad_dir"},  {24'b0, pad_dir},  {24'b0, e[0]});
    chk({phase, " R6 pad_alt"},  {24'b0, pad_alt},  {24'b0, e[1]});
    chk({phase, " R3 pad_od"},   {24'b0, pad_od},   {24'b0, e[2]});
    chk({phase, " R6 pad_pu"},   {24'b0, pad_pu},   {24'b0, e[3]});
    chk({phase, " R6 pad_pd"},   {24'b0, pad_pd},   {24'b0, e[4]});
    chk({phase, " R3 pad_slew"}, {24'b0, pad_slew}, {24'b0, e[5]});
    chk({phase, " R6 pad_den"},  {24'b0, pad_den},  {24'b0, e[6]});
    chk({phase, " R7 pad_drv2"}, {24'b0, pad_drv2}, {24'b0, e[7]});
    chk({phase, " R7 pad_drv4"}, {24'b0, pad_drv4}, {24'b0, e[8]});
    chk({phase, " R7 pad_drv8"}, {24'b0, pad_drv8}, {24'b0, e[9]});
  endtask

  task automatic sweep(input string phase);
    logic [7:0] pats [5] = '{8'hFF, 8'h00, 8'hA5, 8'h5A, 8'hC3};
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < 10; i++) wr(A_LIST[i], {24'hABCDEF, pats[p]});
      check_all(phase);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 and R2: reset state as seen on pads and through reads
    chk("R1 reset pad_alt", {24'b0, pad_alt}, {24'b0, RSV});
    chk("R1 reset pad_drv2", {24'b0, pad_drv2}, 32'hFF);
    rst = 0;
    check_all("R1/R2 reset");
    rd(12'h520, v); chk("R2 locked after reset", v, 32'h1);
    rd(12'h524, v); chk("R2 commit reset", v, {24'b0, ~RSV & CONN});

    // locked: reserved guarded bits must hold
    sweep("locked");
    wr(12'h524, 32'hFF);
    rd(12'h524, v); chk("R5 commit while locked", v, {24'b0, ~RSV & CONN});

    // wrong key keeps it locked
    wr(12'h520, KEY ^ 32'h1);
    rd(12'h520, v); chk("R4 wrong key", v, 32'h1);
    wr(12'h520, KEY);
    rd(12'h520, v); chk("R4 key unlocks", v, 32'h0);
    wr(12'h524, 32'h05);
    rd(12'h524, v); chk("R5 partial commit", v, {24'b0, (~RSV & CONN) | 8'h05});
    sweep("partial commit");
    wr(12'h524, 32'hFF);
    sweep("full commit");

    // relock then try to withdraw the commit
    wr(12'h520, 32'h0);
    rd(12'h520, v); chk("R4 relocked", v, 32'h1);
    wr(12'h524, 32'h00);
    rd(12'h524, v); chk("R5 commit after relock", v, 32'h7F);

    // drive strength: zero writes ignored, ones move the pin
    wr(12'h508, 32'h03); wr(12'h504, 32'h00); wr(12'h500, 32'h00);
    check_all("R7 zero writes");
    wr(12'h504, 32'hFF);
    check_all("R7 all to 4mA");
    chk("R8 pin7 keeps 2mA", {31'b0, pad_drv2[7]}, 32'h1);

    // R8: pin without pad
    wr(12'h400, 32'hFF);
    rd(12'h400, v); chk("R8 unconnected read", v, 32'h7F);
    chk("R8 unconnected pad", {31'b0, pad_dir[7]}, 32'h0);

    // R3: unmapped address
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R3 unmapped read", v, 32'h0);
    rd(12'h5FC, v); chk("R3 unmapped read high", v, 32'h0);
    check_all("R3 after unmapped");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule